// File: doc/BRIEF.md
# DMA Bus Arbitration and Handshake Controller

This block sits inside a memory controller and decides when an external DMA master may take over the processor bus. The master asks for the bus with an active-low request. The controller lets any processor memory cycle that is already running finish. It then holds the processor with an active-low bus-hold and drives the processor's address, control and data output enables to their inactive level. Only after that does it assert an active-low grant. When the processor is powered down, its outputs are already floating, so the controller skips the hold sequence and grants at once.

While the bus is granted, the master starts an access by raising its address strobe. The controller checks that the size code is the word encoding. It then starts the memory side and answers with a one-cycle active-low data-ready pulse, or with an active-low exception pulse when the access cannot be served. A single enable bit, set by reset and writable through a one-bit configuration port, permits or blocks DMA. Memory timing is modelled by a request/done/error handshake.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, grant, bus-hold, data-ready and exception are all high (inactive), and the three processor output enables are low (active). The DMA enable bit comes out of reset set, so a request is served without any configuration write.
- R2: With DMA enabled, not powered down and no processor cycle in flight, a request sampled low at clock edge k drives bus-hold low and all three output enables high after edge k. Grant goes low after edge k+1, so grant never falls without bus-hold having been low in the cycle before.
- R3: While the processor busy input is sampled high, bus-hold is not asserted. Bus-hold goes low after the first edge that samples busy low with the request still pending.
- R4: Once grant is low, it stays low for as long as the request is sampled low.
- R5: When the request is first sampled high at edge e during a normal grant, grant goes high after edge e. Bus-hold goes high after edge e+1. The output enables return low after edge e+2.
- R6: In power-down mode, a request sampled at edge k drives grant low after edge k. Bus-hold and the output enables are left untouched. Grant goes high after the first edge that samples the request high.
- R7: Writing 0 to the enable bit (write strobe high, data 0, taken at a clock edge) makes requests ignored in both normal and power-down mode: grant and bus-hold stay high. Writing 1 restores service.
- R8: While granted, an address strobe sampled high with size code 2'b10 (word) raises the memory request after that edge. The memory request stays high until memory done is sampled. Data-ready is low for exactly the one cycle after that edge when memory error is low.
- R9: If memory error is high when memory done is sampled, the exception output is low for exactly one cycle after that edge, and data-ready stays high.
- R10: While granted, an address strobe sampled high with any size code other than 2'b10 raises no memory request. The exception output is low for exactly the one cycle after that edge.
- R11: An address strobe while grant is high (not granted) raises no memory request and produces no response.
- R12: Data-ready and exception are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the DMA master |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the DMA enable bit |
| cfg_dma_en | input | 1 | Value written to the DMA enable bit |
| pwr_down | input | 1 | Processor is in power-down mode |
| cpu_busy | input | 1 | A processor memory cycle is in progress |
| dma_req_n | input | 1 | Active-low bus request from the DMA master |
| dma_gnt_n | output | 1 | Active-low bus grant to the DMA master |
| bus_hold_n | output | 1 | Active-low hold to the processor |
| cpu_aoe_n | output | 1 | Processor address output enable, active low |
| cpu_coe_n | output | 1 | Processor control output enable, active low |
| cpu_doe_n | output | 1 | Processor data output enable, active low |
| dma_as | input | 1 | DMA address strobe, high when the address is valid |
| dma_size | input | 2 | DMA transfer size code; 2'b10 is a word |
| mem_req | output | 1 | Memory access in progress for the DMA master |
| mem_done | input | 1 | Memory side has completed the access |
| mem_err | input | 1 | Memory side reports the access as invalid |
| dma_rdy_n | output | 1 | Active-low data-ready pulse |
| dma_mexc_n | output | 1 | Active-low memory exception pulse |

## Verification
The assertions assume the master keeps its request low until it has seen the response to its last access. They also assume memory done is raised only while the memory request is high, and the processor busy input stays low while the bus is held. The bench keeps to these rules. It lowers busy after a fixed number of cycles before any hold. It pulses done only while it observes the memory request, and it releases the request only after the response pulse has been checked. Its sweeps cover busy lengths, every size code, several memory latencies and both error values, in normal, power-down and disabled modes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ARB_IDLE   = 3'd0,
    ARB_WAIT   = 3'd1,
    ARB_HOLD   = 3'd2,
    ARB_GRANT  = 3'd3,
    ARB_UNGNT  = 3'd4,
    ARB_UNHOLD = 3'd5,
    ARB_PDGNT  = 3'd6
  } arb_st_e;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_BUSY = 1'b1
  } xf_st_e;

endpackage

// File: rtl/dma_cfg_bit.sv
module dma_cfg_bit #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);

  logic q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic req,
  input  logic cpu_busy,
  input  logic pwr_down,
  output logic gnt,
  output logic hold,
  output logic oe_off
);

  arb_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARB_IDLE: begin
        if (req && dma_en) begin
          if (pwr_down)      st_d = ARB_PDGNT;
          else if (cpu_busy) st_d = ARB_WAIT;
          else               st_d = ARB_HOLD;
        end
      end
      ARB_WAIT: begin
        if (!req || !dma_en) st_d = ARB_IDLE;
        else if (!cpu_busy)  st_d = ARB_HOLD;
      end
      ARB_HOLD: begin
        if (!req || !dma_en) st_d = ARB_UNHOLD;
        else                 st_d = ARB_GRANT;
      end
      ARB_GRANT:  if (!req) st_d = ARB_UNGNT;
      ARB_UNGNT:  st_d = ARB_UNHOLD;
      ARB_UNHOLD: st_d = ARB_IDLE;
      ARB_PDGNT:  if (!req) st_d = ARB_IDLE;
      default:    st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    gnt    = (st_q == ARB_GRANT) || (st_q == ARB_PDGNT);
    hold   = (st_q == ARB_HOLD) || (st_q == ARB_GRANT) || (st_q == ARB_UNGNT);
    oe_off = hold || (st_q == ARB_UNHOLD);
  end

endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_arb_pkg::*;
#(
  parameter int          SIZE_W    = 2,
  parameter logic [SIZE_W-1:0] WORD_CODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              granted,
  input  logic              strobe,
  input  logic [SIZE_W-1:0] size,
  input  logic              mem_done,
  input  logic              mem_err,
  output logic              mem_req,
  output logic              rsp_rdy,
  output logic              rsp_exc
);

  xf_st_e st_q, st_d;
  logic   rdy_d, exc_d;
  logic   size_ok;

  assign size_ok = (size == WORD_CODE);

  always_comb begin
    st_d  = st_q;
    rdy_d = 1'b0;
    exc_d = 1'b0;
    case (st_q)
      XF_IDLE: begin
        if (granted && strobe) begin
          if (size_ok) st_d  = XF_BUSY;
          else         exc_d = 1'b1;
        end
      end
      XF_BUSY: begin
        if (mem_done) begin
          st_d  = XF_IDLE;
          rdy_d = !mem_err;
          exc_d = mem_err;
        end
      end
      default: st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XF_IDLE;
      rsp_rdy <= 1'b0;
      rsp_exc <= 1'b0;
    end else begin
      st_q    <= st_d;
      rsp_rdy <= rdy_d;
      rsp_exc <= exc_d;
    end
  end

  assign mem_req = (st_q == XF_BUSY);

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int                SIZE_W    = 2,
  parameter logic [SIZE_W-1:0] WORD_CODE = 2'b10,
  parameter logic              EN_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dma_en,
  input  logic              pwr_down,
  input  logic              cpu_busy,
  input  logic              dma_req_n,
  output logic              dma_gnt_n,
  output logic              bus_hold_n,
  output logic              cpu_aoe_n,
  output logic              cpu_coe_n,
  output logic              cpu_doe_n,
  input  logic              dma_as,
  input  logic [SIZE_W-1:0] dma_size,
  output logic              mem_req,
  input  logic              mem_done,
  input  logic              mem_err,
  output logic              dma_rdy_n,
  output logic              dma_mexc_n
);

  logic dma_en_q;
  logic gnt, hold, oe_off;
  logic rsp_rdy, rsp_exc;

  dma_cfg_bit #(.RST_VAL(EN_RST)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_val (cfg_dma_en),
    .q      (dma_en_q)
  );

  dma_arb_fsm u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en   (dma_en_q),
    .req      (!dma_req_n),
    .cpu_busy (cpu_busy),
    .pwr_down (pwr_down),
    .gnt      (gnt),
    .hold     (hold),
    .oe_off   (oe_off)
  );

  dma_xfer_ctl #(.SIZE_W(SIZE_W), .WORD_CODE(WORD_CODE)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .granted  (gnt),
    .strobe   (dma_as),
    .size     (dma_size),
    .mem_done (mem_done),
    .mem_err  (mem_err),
    .mem_req  (mem_req),
    .rsp_rdy  (rsp_rdy),
    .rsp_exc  (rsp_exc)
  );

  assign dma_gnt_n  = !gnt;
  assign bus_hold_n = !hold;
  assign cpu_aoe_n  = oe_off;
  assign cpu_coe_n  = oe_off;
  assign cpu_doe_n  = oe_off;
  assign dma_rdy_n  = !rsp_rdy;
  assign dma_mexc_n = !rsp_exc;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int                SIZE_W    = 2,
  parameter logic [SIZE_W-1:0] WORD_CODE = 2'b10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_en_q,
  input logic              pwr_down,
  input logic              cpu_busy,
  input logic              dma_req_n,
  input logic              dma_gnt_n,
  input logic              bus_hold_n,
  input logic              cpu_aoe_n,
  input logic              cpu_coe_n,
  input logic              cpu_doe_n,
  input logic              dma_as,
  input logic [SIZE_W-1:0] dma_size,
  input logic              mem_req,
  input logic              mem_done,
  input logic              mem_err,
  input logic              dma_rdy_n,
  input logic              dma_mexc_n
);

  // R12
  rdy_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dma_rdy_n && !dma_mexc_n));

  // R2
  gnt_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_gnt_n) |-> ($past(!bus_hold_n) || $past(pwr_down)));

  // R2
  oe_off_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_gnt_n && !bus_hold_n) |-> (cpu_aoe_n && cpu_coe_n && cpu_doe_n));

  // R3
  busy_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && bus_hold_n) |=> bus_hold_n);

  // R4
  gnt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_gnt_n && !dma_req_n) |=> !dma_gnt_n);

  // R5
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_gnt_n) && !bus_hold_n) |=> (bus_hold_n && cpu_aoe_n));

  // R7
  disabled_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en_q && dma_gnt_n) |=> dma_gnt_n);

  // R8
  mem_req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> mem_req);

  // R8
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_rdy_n |-> $past(mem_req && mem_done && !mem_err));

  // R10
  bad_size_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_as && !dma_gnt_n && !mem_req && (dma_size != WORD_CODE)) |=> (!mem_req && !dma_mexc_n));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.SIZE_W(SIZE_W), .WORD_CODE(WORD_CODE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_en_q   (dma_en_q),
  .pwr_down   (pwr_down),
  .cpu_busy   (cpu_busy),
  .dma_req_n  (dma_req_n),
  .dma_gnt_n  (dma_gnt_n),
  .bus_hold_n (bus_hold_n),
  .cpu_aoe_n  (cpu_aoe_n),
  .cpu_coe_n  (cpu_coe_n),
  .cpu_doe_n  (cpu_doe_n),
  .dma_as     (dma_as),
  .dma_size   (dma_size),
  .mem_req    (mem_req),
  .mem_done   (mem_done),
  .mem_err    (mem_err),
  .dma_rdy_n  (dma_rdy_n),
  .dma_mexc_n (dma_mexc_n)
);

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_dma_en, pwr_down, cpu_busy, dma_req_n;
  logic       dma_gnt_n, bus_hold_n, cpu_aoe_n, cpu_coe_n, cpu_doe_n;
  logic       dma_as;
  logic [1:0] dma_size;
  logic       mem_req, mem_done, mem_err, dma_rdy_n, dma_mexc_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_bus_arbiter u_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dma_en(cfg_dma_en),
    .pwr_down(pwr_down), .cpu_busy(cpu_busy), .dma_req_n(dma_req_n),
    .dma_gnt_n(dma_gnt_n), .bus_hold_n(bus_hold_n), .cpu_aoe_n(cpu_aoe_n),
    .cpu_coe_n(cpu_coe_n), .cpu_doe_n(cpu_doe_n), .dma_as(dma_as),
    .dma_size(dma_size), .mem_req(mem_req), .mem_done(mem_done),
    .mem_err(mem_err), .dma_rdy_n(dma_rdy_n), .dma_mexc_n(dma_mexc_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] oes();
    return {cpu_aoe_n, cpu_coe_n, cpu_doe_n};
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // R2 / R3: request with a processor cycle lasting busy_len sampled edges
  task automatic arb_req(input int busy_len);
    dma_req_n = 1'b0;
    cpu_busy  = (busy_len > 0);
    for (int cyc = 1; cyc <= busy_len + 2; cyc++) begin
      step();
      if (cyc == busy_len) cpu_busy = 1'b0;
      chk("R3 hold after busy", bus_hold_n, (cyc >= busy_len + 1) ? 1'b0 : 1'b1);
      chk("R2 oe off with hold", oes(), (cyc >= busy_len + 1) ? 3'b111 : 3'b000);
      chk("R2 gnt one cycle after hold", dma_gnt_n, (cyc >= busy_len + 2) ? 1'b0 : 1'b1);
    end
  endtask

  // R5: staged release
  task automatic release_bus;
    dma_req_n = 1'b1;
    step();
    chk("R5 gnt dropped", dma_gnt_n, 1'b1);
    chk("R5 hold kept", bus_hold_n, 1'b0);
    chk("R5 oe off stage1", oes(), 3'b111);
    step();
    chk("R5 hold released", bus_hold_n, 1'b1);
    chk("R5 oe off stage2", oes(), 3'b111);
    step();
    chk("R5 oe restored", oes(), 3'b000);
    chk("R5 gnt idle", dma_gnt_n, 1'b1);
  endtask

  // R8 / R9 / R10: one access during grant
  task automatic xfer(input logic [1:0] size, input int lat, input logic err);
    dma_as   = 1'b1;
    dma_size = size;
    step();
    dma_as = 1'b0;
    if (size != 2'b10) begin
      chk("R10 bad size exception", dma_mexc_n, 1'b0);
      chk("R10 bad size no rdy", dma_rdy_n, 1'b1);
      chk("R10 bad size no mem", mem_req, 1'b0);
      step();
      chk("R10 exception one cycle", dma_mexc_n, 1'b1);
    end else begin
      chk("R8 mem req raised", mem_req, 1'b1);
      chk("R8 no early rdy", dma_rdy_n, 1'b1);
      for (int i = 0; i < lat; i++) begin
        step();
        chk("R8 mem req held", mem_req, 1'b1);
        chk("R8 rdy waits", dma_rdy_n, 1'b1);
        chk("R9 exc waits", dma_mexc_n, 1'b1);
      end
      mem_done = 1'b1;
      mem_err  = err;
      step();
      mem_done = 1'b0;
      mem_err  = 1'b0;
      chk("R8 rdy pulse", dma_rdy_n, err);
      chk("R9 exception pulse", dma_mexc_n, !err);
      chk("R8 mem req ends", mem_req, 1'b0);
      step();
      chk("R8 rdy one cycle", dma_rdy_n, 1'b1);
      chk("R9 exc one cycle", dma_mexc_n, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_dma_en = 1'b1; pwr_down = 1'b0;
    cpu_busy = 1'b0; dma_req_n = 1'b1; dma_as = 1'b0; dma_size = 2'b10;
    mem_done = 1'b0; mem_err = 1'b0;
    repeat (3) step();
    chk("R1 gnt in reset", dma_gnt_n, 1'b1);
    chk("R1 hold in reset", bus_hold_n, 1'b1);
    chk("R1 oe in reset", oes(), 3'b000);
    chk("R1 rdy/mexc in reset", {dma_rdy_n, dma_mexc_n}, 2'b11);
    rst_n = 1'b1;
    step();
    chk("R1 gnt after reset", dma_gnt_n, 1'b1);
    chk("R1 outputs after reset", {bus_hold_n, dma_rdy_n, dma_mexc_n, mem_req}, 4'b1110);

    // R11: strobe without grant
    dma_as = 1'b1;
    step();
    dma_as = 1'b0;
    chk("R11 no mem req", mem_req, 1'b0);
    chk("R11 no response", {dma_rdy_n, dma_mexc_n}, 2'b11);
    step();
    chk("R11 still quiet", {mem_req, dma_rdy_n, dma_mexc_n}, 3'b011);

    // sweep: busy length, size code, latency, error
    for (int b = 0; b < 4; b++) begin
      arb_req(b);
      repeat (2) begin
        step();
        chk("R4 grant held", dma_gnt_n, 1'b0);
      end
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 3; l++)
          for (int e = 0; e < 2; e++)
            if (s == 2 || (l == 0 && e == 0)) begin
              xfer(s[1:0], l, e[0]);
              chk("R4 grant held over access", dma_gnt_n, 1'b0);
            end
      release_bus();
    end

    // R6: power-down bypass
    pwr_down  = 1'b1;
    dma_req_n = 1'b0;
    step();
    chk("R6 direct grant", dma_gnt_n, 1'b0);
    chk("R6 no hold", bus_hold_n, 1'b1);
    chk("R6 oe untouched", oes(), 3'b000);
    xfer(2'b10, 1, 1'b0);
    xfer(2'b10, 0, 1'b1);
    xfer(2'b01, 0, 1'b0);
    dma_req_n = 1'b1;
    step();
    chk("R6 grant released", dma_gnt_n, 1'b1);
    pwr_down = 1'b0;
    step();

    // R7: disabled
    cfg_we = 1'b1; cfg_dma_en = 1'b0;
    step();
    cfg_we = 1'b0;
    for (int pd = 0; pd < 2; pd++) begin
      pwr_down  = pd[0];
      dma_req_n = 1'b0;
      repeat (4) begin
        step();
        chk("R7 disabled no grant", dma_gnt_n, 1'b1);
        chk("R7 disabled no hold", bus_hold_n, 1'b1);
      end
      dma_req_n = 1'b1;
      step();
    end
    pwr_down = 1'b0;
    cfg_we = 1'b1; cfg_dma_en = 1'b1;
    step();
    cfg_we = 1'b0;
    arb_req(0);
    chk("R7 re-enabled grant", dma_gnt_n, 1'b0);
    release_bus();

    summary();
    $finish;
  end

endmodule